// File: doc/BRIEF.md
# Overflow-Triggered PC Trace Sampler

This unit samples execution for one hardware thread without interrupting it. Software writes a 64-bit control word that holds a reload value and an event selector. An internal counter starts at the reload value and advances on each monitored event. When it passes its all-ones value, the counter wraps, and the unit emits a record to memory through a valid/ready write port. No interrupt is raised.

A second software-written register holds the destination base address, a buffer-size code and a mode bit. In trace mode the monitored event is fixed to clock cycles. Each overflow stores a two-word record holding the program counter and the running event count. Records go into a circular buffer at the base address. In accumulation mode the selected event strobe is counted. Each overflow issues a single add-to-memory request carrying the number of events in the period, and software reads the totals in memory whenever it chooses.

The write port follows valid/ready rules. `wr_valid` is raised for one request at a time. Address, data and the add flag stay unchanged until the cycle in which `wr_ready` is high, and the request is taken in that cycle. A record is only ever in the port or absent. While a record is pending, a further overflow is dropped and flagged.

Top module: `pc_trace_sampler`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `wr_valid` is 0 and `lost_o` is 0. After reset the mode is accumulation, the reload value is 0 and the event select is 0.
- R2: In trace mode the counter advances on every clock cycle, regardless of `evt_i`. In accumulation mode it advances only in cycles where `evt_i[sel]` is 1. `sel` is control-word bits [34:32].
- R3: The counter loads from control-word bits [31:0]. When it holds all ones and an event occurs, it reloads that value in the same cycle and an overflow occurs. A period is therefore 2^32 minus the reload value events, and no event is lost between periods.
- R4: A trace-mode overflow with no record pending emits two requests with `wr_add`=0. The first carries the PC present in the overflow cycle at address base+16*index. The second carries the number of events counted since the last control write, including the overflowing one, at that address plus 8.
- R5: An accumulation-mode overflow with no record pending emits one request with `wr_add`=1 at the base address, carrying the period length (2^32 minus the reload value).
- R6: While `wr_valid` is 1 and `wr_ready` is 0, `wr_valid`, `wr_addr`, `wr_data` and `wr_add` hold their values. The first request appears in the cycle after the overflow, and each accepted word is followed directly by the next word of the record.
- R7: An overflow while any request of a record is still pending sets `lost_o`, which stays set. It does not alter the pending record.
- R8: The record index advances by one when the second word of a trace record is accepted, and wraps at 2^(size+2) records. `size` is base-register bits [3:1]. Writing the base register resets the index to 0.
- R9: Base-register bit 0 selects trace mode (1) or accumulation mode (0). The address is the written value with bits [3:0] cleared.
- R10: A control write loads the counter with the new reload value, clears the event count and clears `lost_o`. An overflow in the same cycle as a control write is suppressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_i | input | 64 | Current program counter of the thread |
| evt_i | input | NUM_EVT | Event strobes, one per event source |
| ctl_we | input | 1 | Control-word write strobe |
| ctl_wdata | input | 64 | Control word: reload [31:0], event select [34:32] |
| base_we | input | 1 | Base-register write strobe |
| base_wdata | input | 64 | Base register: mode [0], size code [3:1], address [63:4] |
| wr_valid | output | 1 | Write request present |
| wr_ready | input | 1 | Memory side accepts the request this cycle |
| wr_addr | output | 64 | Byte address of the request |
| wr_data | output | 64 | Data word of the request |
| wr_add | output | 1 | 1: add data into memory; 0: plain store |
| lost_o | output | 1 | Sticky flag: an overflow was dropped |

## Verification
Trace mode is driven with `wr_ready` held high, which shows the two-word record order and the buffer wrap at two different size codes. It is then driven with `wr_ready` toggling at random, which tests the hold rules, and with `wr_ready` held low, which must produce a lost sample that a later control write clears. Accumulation mode gets random strobes on the selected and unselected event lines, which separates correct event selection from a counter that counts cycles. Control writes landing on an overflow, and reload values giving periods of one or two events, test the same-cycle reload and the suppression rule.

// File: rtl/tsamp_pkg.sv
package tsamp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PC   = 2'd1,
    ST_CNT  = 2'd2,
    ST_ACC  = 2'd3
  } wr_state_e;

  localparam int WORD_W   = 64;
  localparam int REC_LSB  = 4;   // 16 bytes per trace record
endpackage

// File: rtl/tsamp_cfg_regs.sv
module tsamp_cfg_regs #(
  parameter int CNT_W  = 32,
  parameter int SEL_W  = 3,
  parameter int SIZE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [63:0]       ctl_wdata,
  input  logic              base_we,
  input  logic [63:0]       base_wdata,
  output logic [CNT_W-1:0]  load_q,
  output logic [SEL_W-1:0]  sel_q,
  output logic              trace_q,
  output logic [SIZE_W-1:0] size_q,
  output logic [63:0]       base_q
);
  localparam int SEL_LO = CNT_W;
  localparam int SEL_HI = CNT_W + SEL_W - 1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_q  <= '0;
      sel_q   <= '0;
      trace_q <= 1'b0;
      size_q  <= '0;
      base_q  <= '0;
    end else begin
      if (ctl_we) begin
        load_q <= ctl_wdata[CNT_W-1:0];
        sel_q  <= ctl_wdata[SEL_HI:SEL_LO];
      end
      if (base_we) begin
        trace_q <= base_wdata[0];
        size_q  <= base_wdata[SIZE_W:1];
        base_q  <= {base_wdata[63:4], 4'b0000};
      end
    end
  end
endmodule

// File: rtl/tsamp_counter.sv
module tsamp_counter #(
  parameter int CNT_W   = 32,
  parameter int NUM_EVT = 8,
  parameter int SEL_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_we,
  input  logic [CNT_W-1:0]   new_load,
  input  logic [CNT_W-1:0]   load_q,
  input  logic [SEL_W-1:0]   sel_q,
  input  logic               trace_q,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic               ovf_o,
  output logic [63:0]        snap_cnt_o,
  output logic [63:0]        period_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [63:0]      total_q;
  logic             evt_sel;
  logic             inc;

  assign evt_sel    = evt_i[sel_q];
  // trace mode counts clock cycles
  assign inc        = trace_q | evt_sel;
  assign ovf_o      = !ctl_we && inc && (cnt_q == {CNT_W{1'b1}});
  assign snap_cnt_o = total_q + 64'(inc);
  assign period_o   = (64'd1 << CNT_W) - 64'(load_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      total_q <= '0;
    end else if (ctl_we) begin
      cnt_q   <= new_load;
      total_q <= '0;
    end else if (inc) begin
      cnt_q   <= (cnt_q == {CNT_W{1'b1}}) ? load_q : cnt_q + 1'b1;
      total_q <= total_q + 64'd1;
    end
  end

  // R3
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> cnt_q == $past(load_q));

  // R10
  ctl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> (cnt_q == $past(new_load) && total_q == 64'd0));
endmodule

// File: rtl/tsamp_writer.sv
module tsamp_writer
  import tsamp_pkg::*;
#(
  parameter int SIZE_W      = 3,
  parameter int MIN_REC_LOG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ovf_i,
  input  logic              trace_i,
  input  logic [63:0]       base_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              base_we,
  input  logic              ctl_we,
  input  logic [63:0]       pc_i,
  input  logic [63:0]       snap_i,
  input  logic [63:0]       period_i,
  input  logic              wr_ready,
  output logic              wr_valid,
  output logic [63:0]       wr_addr,
  output logic [63:0]       wr_data,
  output logic              wr_add,
  output logic              lost_o
);
  localparam int IDX_W = (1 << SIZE_W) - 1 + MIN_REC_LOG;

  wr_state_e        st_q;
  logic [63:0]      addr_q, d0_q, d1_q;
  logic [IDX_W-1:0] idx_q, idx_mask, idx_nxt;
  logic [63:0]      rec_addr;

  assign idx_mask = ~({IDX_W{1'b1}} << (32'(size_i) + MIN_REC_LOG));
  assign idx_nxt  = (idx_q + 1'b1) & idx_mask;
  assign rec_addr = base_i + (64'(idx_q) << REC_LSB);

  assign wr_valid = (st_q != ST_IDLE);
  assign wr_addr  = (st_q == ST_CNT) ? addr_q + 64'd8 : addr_q;
  assign wr_data  = (st_q == ST_CNT) ? d1_q : d0_q;
  assign wr_add   = (st_q == ST_ACC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      d0_q   <= '0;
      d1_q   <= '0;
      idx_q  <= '0;
      lost_o <= 1'b0;
    end else begin
      case (st_q)
        ST_PC:  if (wr_ready) st_q <= ST_CNT;
        ST_CNT: if (wr_ready) st_q <= ST_IDLE;
        ST_ACC: if (wr_ready) st_q <= ST_IDLE;
        default: begin
          if (ovf_i) begin
            if (trace_i) begin
              st_q   <= ST_PC;
              addr_q <= rec_addr;
              d0_q   <= pc_i;
              d1_q   <= snap_i;
            end else begin
              st_q   <= ST_ACC;
              addr_q <= base_i;
              d0_q   <= period_i;
            end
          end
        end
      endcase

      if (ctl_we)
        lost_o <= 1'b0;
      else if (ovf_i && st_q != ST_IDLE)
        lost_o <= 1'b1;

      if (base_we)
        idx_q <= '0;
      else if (st_q == ST_CNT && wr_ready)
        idx_q <= idx_nxt;
    end
  end

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) &&
                                 $stable(wr_data) && $stable(wr_add)));

  // R4
  second_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PC && wr_ready) |=> (wr_valid && !wr_add &&
                                     wr_addr == $past(wr_addr) + 64'd8));

  // R7
  lost_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lost_o) |-> ($past(ovf_i) && $past(st_q) != ST_IDLE));

  // R5
  acc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_add && wr_ready) |=> !(wr_valid && $stable(wr_addr) && !wr_add));
endmodule

// File: rtl/pc_trace_sampler.sv
module pc_trace_sampler #(
  parameter int CNT_W       = 32,
  parameter int NUM_EVT     = 8,
  parameter int SIZE_W      = 3,
  parameter int MIN_REC_LOG = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [63:0]        pc_i,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               ctl_we,
  input  logic [63:0]        ctl_wdata,
  input  logic               base_we,
  input  logic [63:0]        base_wdata,
  output logic               wr_valid,
  input  logic               wr_ready,
  output logic [63:0]        wr_addr,
  output logic [63:0]        wr_data,
  output logic               wr_add,
  output logic               lost_o
);
  localparam int SEL_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

  logic [CNT_W-1:0]  load_q;
  logic [SEL_W-1:0]  sel_q;
  logic              trace_q;
  logic [SIZE_W-1:0] size_q;
  logic [63:0]       base_q;
  logic              ovf;
  logic [63:0]       snap_cnt, period;

  tsamp_cfg_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W), .SIZE_W(SIZE_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .base_we(base_we), .base_wdata(base_wdata),
    .load_q(load_q), .sel_q(sel_q), .trace_q(trace_q),
    .size_q(size_q), .base_q(base_q)
  );

  tsamp_counter #(.CNT_W(CNT_W), .NUM_EVT(NUM_EVT), .SEL_W(SEL_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .ctl_we(ctl_we), .new_load(ctl_wdata[CNT_W-1:0]),
    .load_q(load_q), .sel_q(sel_q), .trace_q(trace_q), .evt_i(evt_i),
    .ovf_o(ovf), .snap_cnt_o(snap_cnt), .period_o(period)
  );

  tsamp_writer #(.SIZE_W(SIZE_W), .MIN_REC_LOG(MIN_REC_LOG)) u_wr (
    .clk(clk), .rst_n(rst_n),
    .ovf_i(ovf), .trace_i(trace_q), .base_i(base_q), .size_i(size_q),
    .base_we(base_we), .ctl_we(ctl_we), .pc_i(pc_i),
    .snap_i(snap_cnt), .period_i(period), .wr_ready(wr_ready),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_add(wr_add), .lost_o(lost_o)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!wr_valid && !lost_o));
endmodule

// File: tb/pc_trace_sampler_test.sv
module pc_trace_sampler_test;
  localparam int CLK_PERIOD = 10;
  localparam int NEVT = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [63:0]     pc_i = 64'h4000_0000;
  logic [NEVT-1:0] evt_i = '0;
  logic            ctl_we = 1'b0, base_we = 1'b0, wr_ready = 1'b0;
  logic [63:0]     ctl_wdata = '0, base_wdata = '0;
  logic            wr_valid, wr_add, lost_o;
  logic [63:0]     wr_addr, wr_data;

  int vectors = 0, fails = 0, wd = 0;

  pc_trace_sampler uut (
    .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .evt_i(evt_i),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .base_we(base_we), .base_wdata(base_wdata),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_add(wr_add), .lost_o(lost_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model state
  logic [31:0] m_cnt, m_load;
  logic [2:0]  m_sel, m_size;
  logic        m_trace, m_lost;
  logic [63:0] m_base, m_total;
  int          m_idx;
  logic [63:0] qa[$], qd[$];
  bit          qadd[$], qlast[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_load = 0; m_sel = 0; m_size = 0; m_trace = 0; m_lost = 0;
      m_base = 0; m_total = 0; m_idx = 0;
      qa.delete(); qd.delete(); qadd.delete(); qlast.delete();
    end else begin
      bit busy, done_tr, inc, ovf;
      busy = (qa.size() != 0);
      done_tr = 0;
      if (busy && wr_ready) begin
        done_tr = qlast[0];
        void'(qa.pop_front()); void'(qd.pop_front());
        void'(qadd.pop_front()); void'(qlast.pop_front());
      end
      inc = m_trace || evt_i[m_sel];
      ovf = 0;
      if (ctl_we) begin
        m_cnt = ctl_wdata[31:0]; m_load = ctl_wdata[31:0];
        m_sel = ctl_wdata[34:32]; m_total = 0; m_lost = 0;
      end else if (inc) begin
        m_total = m_total + 1;
        if (m_cnt == 32'hFFFF_FFFF) begin ovf = 1; m_cnt = m_load; end
        else m_cnt = m_cnt + 1;
      end
      if (ovf) begin
        if (busy) m_lost = 1;
        else if (m_trace) begin
          qa.push_back(m_base + 64'(m_idx) * 16); qd.push_back(pc_i); qadd.push_back(0); qlast.push_back(0);
          qa.push_back(m_base + 64'(m_idx) * 16 + 8); qd.push_back(m_total); qadd.push_back(0); qlast.push_back(1);
        end else begin
          qa.push_back(m_base); qd.push_back(64'h1_0000_0000 - 64'(m_load));
          qadd.push_back(1); qlast.push_back(0);
        end
      end
      if (base_we) m_idx = 0;
      else if (done_tr) m_idx = (m_idx + 1) % (4 << m_size);
      if (base_we) begin
        m_base = {base_wdata[63:4], 4'b0}; m_trace = base_wdata[0]; m_size = base_wdata[3:1];
      end
    end
  end

  task automatic compare(input string tag);
    bit ev = (qa.size() != 0);
    vectors++;
    if (wr_valid !== ev) begin
      fails++; $display("FAIL %s wr_valid actual=%0b expected=%0b", tag, wr_valid, ev);
    end else if (ev) begin
      if (wr_addr !== qa[0] || wr_data !== qd[0] || wr_add !== qadd[0]) begin
        fails++;
        $display("FAIL %s request actual=%h/%h/%0b expected=%h/%h/%0b", tag,
                 wr_addr, wr_data, wr_add, qa[0], qd[0], qadd[0]);
      end
    end
    if (lost_o !== m_lost) begin
      fails++; $display("FAIL %s lost_o actual=%0b expected=%0b", tag, lost_o, m_lost);
    end
  endtask

  task automatic tick(input string tag);
    @(negedge clk);
    compare(tag);
    ctl_we = 1'b0; base_we = 1'b0;
    pc_i = pc_i + 64'd4;
  endtask

  task automatic set_ctl(input logic [31:0] ld, input logic [2:0] sel);
    ctl_we = 1'b1; ctl_wdata = {29'd0, sel, ld};
  endtask

  task automatic set_base(input logic [63:0] a, input logic [2:0] sz, input logic md);
    base_we = 1'b1; base_wdata = {a[63:4], sz, md};
  endtask

  // watchdog
  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      fails++; $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) begin
      @(negedge clk); vectors++;
      if (wr_valid !== 1'b0 || lost_o !== 1'b0) begin
        fails++; $display("FAIL R1 reset actual=%0b/%0b expected=0/0", wr_valid, lost_o);
      end
    end
    rst_n = 1'b1;
    tick("R1");

    // R9 R3 R4 R6 R8: trace mode, ready high, 4-record buffer wraps
    set_base(64'h1000, 3'd0, 1'b1); tick("R9");
    set_ctl(32'hFFFF_FFF9, 3'd0); wr_ready = 1'b1;
    for (int i = 0; i < 80; i++) tick("R2 R3 R4 R8");

    // R6: random back-pressure
    for (int i = 0; i < 150; i++) begin
      wr_ready = $urandom_range(1, 0); tick("R6");
    end

    // R7 then R10: stall until a sample is lost, clear it by a control write
    wr_ready = 1'b0;
    for (int i = 0; i < 60; i++) tick("R7");
    wr_ready = 1'b1;
    for (int i = 0; i < 3; i++) tick("R7");
    set_ctl(32'hFFFF_FFF9, 3'd0);
    for (int i = 0; i < 40; i++) tick("R10");

    // R8: larger buffer, new base resets the index
    set_base(64'h2008, 3'd1, 1'b1); tick("R8 R9");
    set_ctl(32'hFFFF_FFFB, 3'd0);
    for (int i = 0; i < 120; i++) tick("R8");

    // R2 R5: accumulation on event line 3 with noise on other lines
    set_base(64'h3000, 3'd0, 1'b0); tick("R9");
    set_ctl(32'hFFFF_FFFC, 3'd3);
    for (int i = 0; i < 200; i++) begin
      evt_i = NEVT'($urandom); wr_ready = $urandom_range(1, 0); tick("R2 R5");
    end
    evt_i = '0;
    for (int i = 0; i < 20; i++) begin
      wr_ready = 1'b1; tick("R2");
    end

    // R10 R3: short period in trace mode, control writes landing on overflows
    set_base(64'h5000, 3'd2, 1'b1); tick("R9");
    for (int i = 0; i < 100; i++) begin
      if (i % 3 == 0) set_ctl(32'hFFFF_FFFE, 3'd0);
      wr_ready = $urandom_range(1, 0); tick("R10 R3");
    end

    // R3 R7: period of one event, overflow every cycle
    set_ctl(32'hFFFF_FFFF, 3'd0);
    for (int i = 0; i < 60; i++) begin
      wr_ready = $urandom_range(1, 0); tick("R3 R7");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule